// File: doc/BRIEF.md
# Regroupable Bidirectional Lane Shift Register

A 96-stage serial shift register whose stages can be regrouped into 2, 3, 4 or 6 parallel lanes by a 2-bit lane-select input. The lanes are interleaved: with n lanes, lane k (1-based) owns stages k, k+n, k+2n and so on. Because of this, neighbouring stage positions always sit in different lanes, and n bits enter the register on every clock.

A direction input chooses which way the data moves. Each lane has an end port at the low-numbered end and one at the high-numbered end. Whichever end acts as the entry point for the current direction takes data in. The other end drives the lane's last stage out, with an output enable. The whole stage vector is exported in parallel so that a downstream latch can capture it.

An asynchronous active-low clear empties every stage. The same clear also acts as the block's reset.

Top module: `lane_shift_array`

## Requirements
- R1: The lane count follows `lane_sel`: 2'b11 gives 2 lanes of 48 stages, 2'b10 gives 3 lanes of 32, 2'b01 gives 4 lanes of 24, and 2'b00 gives 6 lanes of 16. Exactly one output enable is high for each lane in use.
- R2: On each rising clock edge with `dir_right` = 1 and n lanes, stage i takes the old value of stage i-n. Stages 1..n take `left_in` bits 0..n-1. Stage i appears on `stages` bit i-1.
- R3: On each rising clock edge with `dir_right` = 0 and n lanes, stage i takes the old value of stage i+n. Stage 96-n+k takes `right_in` bit k-1, for k = 1..n.
- R4: While `dir_right` = 1, `right_out` bit k-1 shows stage 96-n+k and `right_oe` is high for every used lane. `left_oe` and `left_out` are all zero.
- R5: While `dir_right` = 0, `left_out` bit k-1 shows stage k and `left_oe` is high for every used lane. `right_oe` and `right_out` are all zero.
- R6: Port bits of lanes numbered above n have no effect: their input bits never reach a stage, and their output and enable bits stay low.
- R7: While `clr_n` is low, every stage reads 0. This holds at once, without a clock edge, and overrides any clock edge that arrives during the clear.
- R8: Changing `lane_sel` does not alter the stage contents. Only the lane grouping used for later edges and for the port outputs changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; data moves on its rising edge |
| clr_n | input | 1 | Asynchronous active-low clear of all stages |
| lane_sel | input | 2 | Lane grouping select (see R1) |
| dir_right | input | 1 | 1: move toward higher stages; 0: toward lower stages |
| left_in | input | 6 | Per-lane entry data at the low end (right shift) |
| left_out | output | 6 | Per-lane exit data at the low end (left shift) |
| left_oe | output | 6 | Output enable of the low-end ports |
| right_in | input | 6 | Per-lane entry data at the high end (left shift) |
| right_out | output | 6 | Per-lane exit data at the high end (right shift) |
| right_oe | output | 6 | Output enable of the high-end ports |
| stages | output | 96 | Parallel stage contents; bit i-1 is stage i |

## Verification
The bench builds the block with the default of 96 stages. At this size every one of the four lane groupings runs at full length. Lanes 5 and 6 exist but sit idle in the 2-, 3- and 4-lane groupings, so the bench can drive them with ones and show that nothing leaks in. Random runs mix all groupings and both directions, and regroup the register while it holds data. Directed cases cover the clear arriving between edges and the first entry bits in each direction.

// File: rtl/lsa_pkg.sv
`timescale 1ns/1ps
package lsa_pkg;

  localparam int unsigned MAX_LANES  = 6;
  localparam int unsigned MODE_COUNT = 4;

  typedef enum logic [1:0] {
    GROUP_SIX   = 2'b00,
    GROUP_FOUR  = 2'b01,
    GROUP_THREE = 2'b10,
    GROUP_TWO   = 2'b11
  } lane_group_e;

  // number of interleaved lanes for a lane-select code
  function automatic int unsigned lanes_for_mode(input logic [1:0] sel);
    case (lane_group_e'(sel))
      GROUP_TWO:   return 2;
      GROUP_THREE: return 3;
      GROUP_FOUR:  return 4;
      default:     return 6;
    endcase
  endfunction

endpackage

// File: rtl/lsa_mode_decode.sv
`timescale 1ns/1ps
module lsa_mode_decode
  import lsa_pkg::*;
(
  input  logic [1:0]           lane_sel,
  output logic [2:0]           lane_cnt,
  output logic [MAX_LANES-1:0] lane_en
);

  always_comb begin
    int unsigned n;
    n = lanes_for_mode(lane_sel);
    lane_cnt = 3'(n);
    for (int unsigned k = 0; k < MAX_LANES; k++) begin
      lane_en[k] = (k < n);
    end
  end

endmodule

// File: rtl/lsa_stage_core.sv
`timescale 1ns/1ps
module lsa_stage_core
  import lsa_pkg::*;
#(
  parameter int unsigned STAGES = 96
) (
  input  logic                 clk,
  input  logic                 clr_n,
  input  logic [1:0]           lane_sel,
  input  logic                 dir_right,
  input  logic [MAX_LANES-1:0] left_in,
  input  logic [MAX_LANES-1:0] right_in,
  output logic [STAGES-1:0]    stage_q
);

  logic [STAGES-1:0] stage_d;
  logic [STAGES-1:0] nxt_by_mode [MODE_COUNT];

  // one candidate next state per grouping; the select picks one
  for (genvar m = 0; m < MODE_COUNT; m++) begin : g_mode
    localparam int unsigned N = lanes_for_mode(2'(m));
    logic [STAGES-1:0] to_right;
    logic [STAGES-1:0] to_left;
    for (genvar i = 0; i < STAGES; i++) begin : g_bit
      if (i < N) begin : g_rhead
        assign to_right[i] = left_in[i];
      end else begin : g_rbody
        assign to_right[i] = stage_q[i-N];
      end
      if (i >= STAGES - N) begin : g_lhead
        assign to_left[i] = right_in[i-(STAGES-N)];
      end else begin : g_lbody
        assign to_left[i] = stage_q[i+N];
      end
    end
    assign nxt_by_mode[m] = dir_right ? to_right : to_left;
  end

  assign stage_d = nxt_by_mode[lane_sel];

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

endmodule

// File: rtl/lsa_end_ports.sv
`timescale 1ns/1ps
module lsa_end_ports
  import lsa_pkg::*;
(
  input  logic [MAX_LANES-1:0] head,
  input  logic [MAX_LANES-1:0] tail,
  input  logic [1:0]           lane_sel,
  input  logic [MAX_LANES-1:0] lane_en,
  input  logic                 dir_right,
  output logic [MAX_LANES-1:0] left_out,
  output logic [MAX_LANES-1:0] left_oe,
  output logic [MAX_LANES-1:0] right_out,
  output logic [MAX_LANES-1:0] right_oe
);

  logic [MAX_LANES-1:0] tail_by_mode [MODE_COUNT];

  // tail holds the top MAX_LANES stages; lane k exits at stage STAGES-N+k
  for (genvar m = 0; m < MODE_COUNT; m++) begin : g_mode
    localparam int unsigned N = lanes_for_mode(2'(m));
    logic [MAX_LANES-1:0] pick;
    for (genvar k = 0; k < MAX_LANES; k++) begin : g_lane
      if (k < N) begin : g_used
        assign pick[k] = tail[MAX_LANES-N+k];
      end else begin : g_idle
        assign pick[k] = 1'b0;
      end
    end
    assign tail_by_mode[m] = pick;
  end

  assign right_out = dir_right ? tail_by_mode[lane_sel] : '0;
  assign right_oe  = dir_right ? lane_en : '0;
  assign left_out  = dir_right ? '0 : (head & lane_en);
  assign left_oe   = dir_right ? '0 : lane_en;

endmodule

// File: rtl/lane_shift_array.sv
`timescale 1ns/1ps
module lane_shift_array
  import lsa_pkg::*;
#(
  parameter int unsigned STAGES = 96
) (
  input  logic                 clk,
  input  logic                 clr_n,
  input  logic [1:0]           lane_sel,
  input  logic                 dir_right,
  input  logic [MAX_LANES-1:0] left_in,
  output logic [MAX_LANES-1:0] left_out,
  output logic [MAX_LANES-1:0] left_oe,
  input  logic [MAX_LANES-1:0] right_in,
  output logic [MAX_LANES-1:0] right_out,
  output logic [MAX_LANES-1:0] right_oe,
  output logic [STAGES-1:0]    stages
);

  logic [2:0]           lane_cnt;
  logic [MAX_LANES-1:0] lane_en;
  logic [STAGES-1:0]    stage_q;
  logic [MAX_LANES-1:0] head_bits;
  logic [MAX_LANES-1:0] tail_bits;

  lsa_mode_decode u_decode (
    .lane_sel (lane_sel),
    .lane_cnt (lane_cnt),
    .lane_en  (lane_en)
  );

  lsa_stage_core #(.STAGES(STAGES)) u_core (
    .clk       (clk),
    .clr_n     (clr_n),
    .lane_sel  (lane_sel),
    .dir_right (dir_right),
    .left_in   (left_in & lane_en),
    .right_in  (right_in & lane_en),
    .stage_q   (stage_q)
  );

  assign head_bits = stage_q[MAX_LANES-1:0];
  assign tail_bits = stage_q[STAGES-1 -: MAX_LANES];

  lsa_end_ports u_ports (
    .head      (head_bits),
    .tail      (tail_bits),
    .lane_sel  (lane_sel),
    .lane_en   (lane_en),
    .dir_right (dir_right),
    .left_out  (left_out),
    .left_oe   (left_oe),
    .right_out (right_out),
    .right_oe  (right_oe)
  );

  assign stages = stage_q;

endmodule

// File: rtl/lsa_checker.sv
`timescale 1ns/1ps
module lsa_checker
  import lsa_pkg::*;
#(
  parameter int unsigned STAGES = 96
) (
  input logic                 clk,
  input logic                 clr_n,
  input logic [1:0]           lane_sel,
  input logic                 dir_right,
  input logic [MAX_LANES-1:0] left_in,
  input logic [MAX_LANES-1:0] right_in,
  input logic [MAX_LANES-1:0] left_out,
  input logic [MAX_LANES-1:0] left_oe,
  input logic [MAX_LANES-1:0] right_out,
  input logic [MAX_LANES-1:0] right_oe,
  input logic [STAGES-1:0]    stages,
  input logic [2:0]           lane_cnt
);

  assert_enable_count_R1: assert property (@(posedge clk) disable iff (!clr_n)
    $countones(left_oe | right_oe) == 32'(lane_cnt));

  assert_three_lanes_R1: assert property (@(posedge clk) disable iff (!clr_n)
    (lane_sel == 2'b10) |-> $countones(left_oe | right_oe) == 3);

  assert_right_entry_R2: assert property (@(posedge clk) disable iff (!clr_n)
    dir_right |=> stages[0] == $past(left_in[0]));

  assert_right_move_R2: assert property (@(posedge clk) disable iff (!clr_n)
    (dir_right && lane_sel == 2'b00) |=> stages[STAGES-1:6] == $past(stages[STAGES-7:0]));

  assert_left_move_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (!dir_right && lane_sel == 2'b11) |=> stages[STAGES-3:0] == $past(stages[STAGES-1:2]));

  assert_left_entry_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (!dir_right && lane_sel == 2'b11) |=> stages[STAGES-1] == $past(right_in[1]));

  assert_port_roles_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (left_oe & right_oe) == '0);

  assert_right_tail_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (dir_right && lane_sel == 2'b11) |-> right_out[1:0] == stages[STAGES-1:STAGES-2]);

  assert_left_head_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (!dir_right && lane_sel == 2'b01) |-> left_out[3:0] == stages[3:0]);

  assert_idle_lanes_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (lane_sel == 2'b11) |-> (left_out[5:2] | right_out[5:2] | left_oe[5:2] | right_oe[5:2]) == 4'b0);

  assert_clear_R7: assert property (@(posedge clk)
    !clr_n |-> stages == '0);

endmodule

bind lane_shift_array lsa_checker #(.STAGES(STAGES)) u_lsa_checker (
  .clk       (clk),
  .clr_n     (clr_n),
  .lane_sel  (lane_sel),
  .dir_right (dir_right),
  .left_in   (left_in),
  .right_in  (right_in),
  .left_out  (left_out),
  .left_oe   (left_oe),
  .right_out (right_out),
  .right_oe  (right_oe),
  .stages    (stages),
  .lane_cnt  (lane_cnt)
);

// File: tb/lane_shift_array_bench.sv
`timescale 1ns/1ps
module lane_shift_array_bench;

  localparam int NST = 96;

  logic            clk = 1'b0;
  logic            clr_n = 1'b0;
  logic [1:0]      lane_sel = 2'b00;
  logic            dir_right = 1'b1;
  logic [5:0]      left_in = '0;
  logic [5:0]      right_in = '0;
  logic [5:0]      left_out, left_oe, right_out, right_oe;
  logic [NST-1:0]  stages;

  logic [NST-1:0]  exp_s = '0;
  int              n_checks = 0;
  int              n_fails = 0;
  bit              done = 1'b0;

  always #2.5 clk = ~clk;

  lane_shift_array u_lane_shift_array (
    .clk(clk), .clr_n(clr_n), .lane_sel(lane_sel), .dir_right(dir_right),
    .left_in(left_in), .left_out(left_out), .left_oe(left_oe),
    .right_in(right_in), .right_out(right_out), .right_oe(right_oe),
    .stages(stages)
  );

  function automatic int lanes_of(input logic [1:0] sel);
    case (sel)
      2'b11: return 2;
      2'b10: return 3;
      2'b01: return 4;
      default: return 6;
    endcase
  endfunction

  // walk each lane from its entry end to its exit end
  function automatic logic [NST-1:0] model_step(input logic [NST-1:0] s, input int n,
                                                input bit dir, input logic [5:0] a,
                                                input logic [5:0] b);
    logic [NST-1:0] r;
    int len;
    len = NST / n;
    r = s;
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < len; j++) begin
        if (dir) r[k + j*n] = (j == 0) ? a[k] : s[k + (j-1)*n];
        else     r[k + j*n] = (j == len-1) ? b[k] : s[k + (j+1)*n];
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_ports(input string req);
    logic [5:0] e_lo, e_loe, e_ro, e_roe;
    int n;
    n = lanes_of(lane_sel);
    e_lo = '0; e_loe = '0; e_ro = '0; e_roe = '0;
    for (int k = 0; k < n; k++) begin
      if (dir_right) begin
        e_ro[k] = exp_s[NST-n+k];
        e_roe[k] = 1'b1;
      end else begin
        e_lo[k] = exp_s[k];
        e_loe[k] = 1'b1;
      end
    end
    check(req, 128'({left_out, left_oe, right_out, right_oe}), 128'({e_lo, e_loe, e_ro, e_roe}));
  endtask

  task automatic check_all();
    check(dir_right ? "R2 stages" : "R3 stages", 128'(stages), 128'(exp_s));
    check(dir_right ? "R4 ports" : "R5 ports", 0, 0);
    n_checks--;
    check_ports(dir_right ? "R4 ports" : "R5 ports");
  endtask

  task automatic run_cycle(input logic [1:0] sel, input bit dir,
                           input logic [5:0] a, input logic [5:0] b);
    lane_sel = sel; dir_right = dir; left_in = a; right_in = b;
    @(posedge clk);
    exp_s = model_step(exp_s, lanes_of(sel), dir, a, b);
    #1;
    check_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);

    // reset state (R7)
    left_in = 6'h3f; right_in = 6'h3f;
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset stages", 128'(stages), 128'(0));
    clr_n = 1'b1;
    left_in = '0; right_in = '0;

    // lane counts per select code (R1)
    for (int c = 0; c < 4; c++) begin
      int want;
      lane_sel = 2'(c); dir_right = 1'b1;
      #0.5;
      want = (c == 3) ? 2 : (c == 2) ? 3 : (c == 1) ? 4 : 6;
      check("R1 enable count", 128'($countones(right_oe)), 128'(want));
    end

    // first entry bits in six-lane right shift (R2)
    run_cycle(2'b00, 1'b1, 6'b101101, 6'b0);
    check("R2 entry bits", 128'(stages[5:0]), 128'(6'b101101));
    run_cycle(2'b00, 1'b1, 6'b000000, 6'b0);
    check("R2 moved by six", 128'(stages[11:6]), 128'(6'b101101));

    // idle lanes driven high never enter (R6)
    for (int t = 0; t < 60; t++) run_cycle(2'b11, t[0], 6'b111100, 6'b111100);
    check("R6 idle inputs", 128'(stages), 128'(exp_s));
    check("R6 idle outputs", 128'({left_out[5:2], left_oe[5:2], right_out[5:2], right_oe[5:2]}), 128'(0));

    // three-lane left entry (R3)
    run_cycle(2'b10, 1'b0, 6'b0, 6'b000111);
    check("R3 entry bits", 128'(stages[NST-1:NST-3]), 128'(3'b111));

    // regroup with data held (R8)
    for (int t = 0; t < 40; t++) run_cycle(2'b00, 1'b1, 6'($urandom), 6'($urandom));
    for (int c = 0; c < 4; c++) begin
      lane_sel = 2'(c);
      #0.5;
      check("R8 contents kept", 128'(stages), 128'(exp_s));
      check_ports("R8 ports regrouped");
    end
    run_cycle(2'b01, 1'b0, 6'b0, 6'b001010);

    // clear between edges and across edges (R7)
    @(posedge clk); exp_s = model_step(exp_s, lanes_of(lane_sel), dir_right, left_in, right_in);
    #1;
    clr_n = 1'b0;
    #0.5;
    check("R7 async clear", 128'(stages), 128'(0));
    left_in = 6'h3f; right_in = 6'h3f;
    repeat (2) @(posedge clk);
    #1;
    check("R7 clear over edges", 128'(stages), 128'(0));
    exp_s = '0;
    clr_n = 1'b1;

    // random mix
    for (int t = 0; t < 600; t++) begin
      run_cycle(2'($urandom), 1'($urandom), 6'($urandom), 6'($urandom));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule